// File: doc/BRIEF.md
# Compare-driven timer counter channel

One up-counting timer channel for a system clock domain. Software programs it through a small register window: a mode word, two compare values (A and C), a command register, and interrupt enable and mask registers. It reads back the live count and a status word. Each count step is taken from one of several clock sources. These are power-of-two taps of the system clock, a slow tick input, an external input, or every system clock. The counter advances once per selected step.

Compare C gives the block its timing behaviour. In reload mode the counter returns to zero after it matches C, which produces periodic events. With the stop bit also set, one match halts the channel, which gives a one-shot delay. Matches on A and C can also set, clear or toggle an output pin. This produces a square wave that a second channel can count through its external input, so two channels chain into a wider counter. A separate synchronous clear input lets the surrounding block zero several channels on the same clock.

Top module: `tmr_chan`

## Requirements
- R1: After reset the count reads 0, the status reads 0, the channel is halted, and both `wave_out` and `irq` are low.
- R2: In free-run mode (mode bit 3 = 0), a step taken at the all-ones count moves the count to 0 and sets status bit 0 (overflow).
- R3: In reload mode (mode bit 3 = 1), a step taken while the count equals compare C moves the count to 0 and sets status bit 2. Starting from 0 with C = N, these events repeat every N+1 steps.
- R4: With mode bit 4 set, the step that matches compare C also halts the channel, so exactly one event occurs. Status bit 4 (running) then reads 0 and the count holds.
- R5: Writing command bit 2 (trigger) zeroes the count. Writing command bits 0 and 2 together zeroes the count and starts counting from 0.
- R6: Command bit 1 halts the channel, and the count holds. Command bit 0 resumes counting from the held value. When bits 0 and 1 are written together, the halt takes effect.
- R7: `irq` is the OR over sources of latched flag AND enable. Writing a 1 to the enable register (offset 4) sets that source's enable bit, and writing a 1 to the mask register (offset 5) clears it. Writing 0xFF to the mask register forces `irq` low.
- R8: Reading the status register (offset 7) returns the flags in bits 2:0 (overflow, A match, C match) and clears them. An event that occurs in the same cycle as the read stays latched.
- R9: Mode bits 6:5 select the pin action on an A match and mode bits 8:7 select the action on a C match: 0 keep, 1 set, 2 clear, 3 toggle. When both match on the same step, the C action is applied after the A action.
- R10: Mode bits 2:0 select the count step: 0, 1, 2 and 3 give one step every 2, 8, 32 and 128 clocks. 4 gives each rising edge of `slow_tick`, 5 gives each rising edge of `ext_clk`, and 6 and 7 give every clock.
- R11: A high `sync_clr` on a clock edge zeroes the count without changing whether the channel runs.
- R12: With A = 0 set, C = 0x8000 clear, and free-run every-clock stepping, `wave_out` is a half-duty wave of period 65536. A second channel stepping on its rising edges forms a 32-bit count {upper, lower} that never decreases once the lower half is past the first few counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status when reading offset 7) |
| bus_addr | input | 3 | Register offset: 0 mode, 1 compare A, 2 compare C, 3 command, 4 enable set, 5 enable clear, 6 count, 7 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| slow_tick | input | 1 | Slow tick source, sampled and edge detected |
| ext_clk | input | 1 | External step source, sampled and edge detected |
| sync_clr | input | 1 | Block-wide synchronous counter clear |
| wave_out | output | 1 | Compare-driven output pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with its default parameters: a 16-bit count, four prescaler taps two octaves apart, and two-stage input samplers. With these values the divide-by-8 and divide-by-128 taps can be measured as exact event intervals, and the full 16-bit wrap is reached in 65536 every-clock steps. Two instances are chained through the pin and external input, which drives the upper half past two carries within the run. The slow-tick path is covered with a bench-generated tick of period 10 clocks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam logic [2:0] A_MODE  = 3'd0;
   localparam logic [2:0] A_CMPA  = 3'd1;
   localparam logic [2:0] A_CMPC  = 3'd2;
   localparam logic [2:0] A_CTRL  = 3'd3;
   localparam logic [2:0] A_IEN   = 3'd4;
   localparam logic [2:0] A_IDIS  = 3'd5;
   localparam logic [2:0] A_COUNT = 3'd6;
   localparam logic [2:0] A_STAT  = 3'd7;

   localparam int NSRC    = 3;
   localparam int SRC_OVF = 0;
   localparam int SRC_CA  = 1;
   localparam int SRC_CC  = 2;
   localparam int ST_RUN  = 4;

   localparam int CTL_EN   = 0;
   localparam int CTL_DIS  = 1;
   localparam int CTL_TRIG = 2;

   localparam logic [2:0] SEL_SLOW = 3'd4;
   localparam logic [2:0] SEL_EXT  = 3'd5;

   typedef enum logic [1:0] {
      PIN_KEEP = 2'd0,
      PIN_SET  = 2'd1,
      PIN_CLR  = 2'd2,
      PIN_TOG  = 2'd3
   } pin_act_e;

   // packed low to high: clk_sel[2:0], reload_c[3], stop_c[4], act_a[6:5], act_c[8:7]
   typedef struct packed {
      pin_act_e   act_c;
      pin_act_e   act_a;
      logic       stop_c;
      logic       reload_c;
      logic [2:0] clk_sel;
   } mode_t;

   localparam int MODE_W = $bits(mode_t);

   function automatic logic pin_apply(pin_act_e a, logic cur);
      case (a)
         PIN_SET: return 1'b1;
         PIN_CLR: return 1'b0;
         PIN_TOG: return ~cur;
         default: return cur;
      endcase
   endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
   import tmr_pkg::*;
#(
   parameter int PRE_TAPS    = 4,
   parameter int PRE_STEP    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   input  logic       slow_in,
   input  logic       ext_in,
   output logic       tick
);
   localparam int PRE_W = PRE_STEP * (PRE_TAPS - 1) + 1;

   if (PRE_TAPS < 1 || PRE_TAPS > 4) begin : g_bad_taps
      $error("tmr_tick_gen: PRE_TAPS must be 1..4");
   end
   if (PRE_STEP < 1) begin : g_bad_step
      $error("tmr_tick_gen: PRE_STEP must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tmr_tick_gen: SYNC_STAGES must be at least 2");
   end

   logic [PRE_W-1:0]    pre_q;
   logic [PRE_TAPS-1:0] tap;
   logic [1:0]          raw;
   logic [1:0]          rise;

   always_ff @(posedge clk) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + PRE_W'(1);
   end

   for (genvar i = 0; i < PRE_TAPS; i++) begin : g_tap
      localparam int LW = 1 + PRE_STEP * i;
      assign tap[i] = &pre_q[LW-1:0];
   end

   assign raw = {ext_in, slow_in};

   for (genvar k = 0; k < 2; k++) begin : g_edge
      logic [SYNC_STAGES:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[SYNC_STAGES-1:0], raw[k]};
      end
      assign rise[k] = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

      AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         rise[k] |=> !rise[k]); // R10
   end

   always_comb begin
      tick = 1'b0;
      case (sel)
         SEL_SLOW:   tick = rise[0];
         SEL_EXT:    tick = rise[1];
         3'd6, 3'd7: tick = 1'b1;
         default: begin
            for (int i = 0; i < PRE_TAPS; i++) begin
               if (sel == 3'(i)) tick = tap[i];
            end
         end
      endcase
   end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  mode_t            mode,
   input  logic [CNT_W-1:0] cmp_a,
   input  logic [CNT_W-1:0] cmp_c,
   input  logic             cmd_en,
   input  logic             cmd_dis,
   input  logic             cmd_trig,
   input  logic             sync_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             running,
   output logic             pin,
   output logic [NSRC-1:0]  ev
);
   logic clr, step, at_top, hit_a, hit_c, pin_n;

   assign clr    = sync_clr | cmd_trig;
   assign step   = running & tick & ~clr;
   assign at_top = &cnt;
   assign hit_a  = step & (cnt == cmp_a);
   assign hit_c  = step & (cnt == cmp_c);

   assign ev[SRC_OVF] = step & at_top;
   assign ev[SRC_CA]  = hit_a;
   assign ev[SRC_CC]  = hit_c;

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (step) cnt <= (mode.reload_c && hit_c) ? '0 : cnt + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     running <= 1'b0;
      else if (cmd_dis)               running <= 1'b0;
      else if (cmd_en)                running <= 1'b1;
      else if (hit_c && mode.stop_c)  running <= 1'b0;
   end

   always_comb begin
      pin_n = pin;
      if (hit_a) pin_n = pin_apply(mode.act_a, pin_n);
      if (hit_c) pin_n = pin_apply(mode.act_c, pin_n);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pin <= 1'b0;
      else        pin <= pin_n;
   end

   AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      sync_clr |=> (cnt == '0)); // R11
   AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_trig |=> (cnt == '0)); // R5
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (step && at_top && !mode.reload_c) |=> (cnt == '0)); // R2
   AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (step && mode.reload_c && cnt == cmp_c) |=> (cnt == '0)); // R3
   AST_STOP_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_c && mode.stop_c && !cmd_en) |=> !running); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !clr) |=> $stable(cnt)); // R6
   AST_PIN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_c && mode.act_c == PIN_CLR) |=> !pin); // R9
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             rd,
   input  logic [2:0]       addr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] rdata,
   input  logic [NSRC-1:0]  ev,
   input  logic [CNT_W-1:0] cnt,
   input  logic             running,
   output mode_t            mode,
   output logic [CNT_W-1:0] cmp_a,
   output logic [CNT_W-1:0] cmp_c,
   output logic             cmd_en,
   output logic             cmd_dis,
   output logic             cmd_trig,
   output logic             irq
);
   if (CNT_W < MODE_W || CNT_W > 32) begin : g_bad_width
      $error("tmr_regs: CNT_W must be between the mode width and 32");
   end

   logic [MODE_W-1:0] mode_q;
   logic [NSRC-1:0]   ien_q, flags_q;
   logic              wr_ctrl, rd_stat;
   logic [CNT_W-1:0]  stat_w;

   assign mode    = mode_t'(mode_q);
   assign wr_ctrl = wr && (addr == A_CTRL);
   assign rd_stat = rd && (addr == A_STAT);
   assign cmd_en   = wr_ctrl & wdata[CTL_EN];
   assign cmd_dis  = wr_ctrl & wdata[CTL_DIS];
   assign cmd_trig = wr_ctrl & wdata[CTL_TRIG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         cmp_a  <= '0;
         cmp_c  <= '0;
         ien_q  <= '0;
      end else if (wr) begin
         case (addr)
            A_MODE: mode_q <= wdata[MODE_W-1:0];
            A_CMPA: cmp_a  <= wdata;
            A_CMPC: cmp_c  <= wdata;
            A_IEN:  ien_q  <= ien_q | wdata[NSRC-1:0];
            A_IDIS: ien_q  <= ien_q & ~wdata[NSRC-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (rd_stat ? '0 : flags_q) | ev;
   end

   assign irq = |(flags_q & ien_q);

   always_comb begin
      stat_w = '0;
      stat_w[NSRC-1:0] = flags_q;
      stat_w[ST_RUN]   = running;
   end

   always_comb begin
      case (addr)
         A_MODE:  rdata = CNT_W'(mode_q);
         A_CMPA:  rdata = cmp_a;
         A_CMPC:  rdata = cmp_c;
         A_IEN:   rdata = CNT_W'(ien_q);
         A_COUNT: rdata = cnt;
         A_STAT:  rdata = stat_w;
         default: rdata = '0;
      endcase
   end

   AST_FLAG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ev[SRC_CC] |=> flags_q[SRC_CC]); // R3
   AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq); // R7
   AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && ev == '0) |=> (flags_q == '0)); // R8
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PRE_TAPS    = 4,
   parameter int PRE_STEP    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [2:0]       bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   input  logic             slow_tick,
   input  logic             ext_clk,
   input  logic             sync_clr,
   output logic             wave_out,
   output logic             irq
);
   mode_t            mode;
   logic [CNT_W-1:0] cmp_a, cmp_c, cnt;
   logic             cmd_en, cmd_dis, cmd_trig, running, tick;
   logic [NSRC-1:0]  ev;

   tmr_regs #(.CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_wr),
      .rd       (bus_rd),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .rdata    (bus_rdata),
      .ev       (ev),
      .cnt      (cnt),
      .running  (running),
      .mode     (mode),
      .cmp_a    (cmp_a),
      .cmp_c    (cmp_c),
      .cmd_en   (cmd_en),
      .cmd_dis  (cmd_dis),
      .cmd_trig (cmd_trig),
      .irq      (irq)
   );

   tmr_tick_gen #(
      .PRE_TAPS    (PRE_TAPS),
      .PRE_STEP    (PRE_STEP),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (mode.clk_sel),
      .slow_in (slow_tick),
      .ext_in  (ext_clk),
      .tick    (tick)
   );

   tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .mode     (mode),
      .cmp_a    (cmp_a),
      .cmp_c    (cmp_c),
      .cmd_en   (cmd_en),
      .cmd_dis  (cmd_dis),
      .cmd_trig (cmd_trig),
      .sync_clr (sync_clr),
      .cnt      (cnt),
      .running  (running),
      .pin      (wave_out),
      .ev       (ev)
   );
endmodule

// File: tb/tmr_chan_bench.sv
module tmr_chan_bench;
   import tmr_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic        sel_hi = 1'b0;
   logic        slow_tick = 1'b0;
   logic        sync_in = 1'b0;
   int          slow_div = 0;
   int          cyc = 0;
   int          n_chk = 0;
   int          n_bad = 0;

   logic [15:0] lo_rdata, hi_rdata;
   logic        lo_wave, lo_irq, hi_wave, hi_irq;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (slow_div == 4) begin
         slow_div  <= 0;
         slow_tick <= ~slow_tick;
      end else begin
         slow_div <= slow_div + 1;
      end
   end

   tmr_chan u_tmr_chan (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr & ~sel_hi), .bus_rd(bus_rd & ~sel_hi),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(lo_rdata),
      .slow_tick(slow_tick), .ext_clk(1'b0), .sync_clr(sync_in),
      .wave_out(lo_wave), .irq(lo_irq)
   );

   tmr_chan u_tmr_chan_hi (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr & sel_hi), .bus_rd(bus_rd & sel_hi),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(hi_rdata),
      .slow_tick(1'b0), .ext_clk(lo_wave), .sync_clr(sync_in),
      .wave_out(hi_wave), .irq(hi_irq)
   );

   task automatic check_eq(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(logic hi, logic [2:0] a, logic [15:0] d);
      @(negedge clk);
      sel_hi = hi; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic hi, logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      sel_hi = hi; bus_addr = a; bus_rd = 1'b1;
      #1 d = hi ? hi_rdata : lo_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic measure(int exp, string tag);
      int t[3];
      int k = 0;
      int guard = 0;
      logic [15:0] d;
      t[0] = 0; t[1] = -100000; t[2] = -200000;
      while (k < 3 && guard < 2000) begin
         @(negedge clk);
         guard++;
         if (lo_irq) begin
            t[k] = cyc;
            k++;
            rd(1'b0, A_STAT, d);
         end
      end
      check_eq({tag, " first interval"}, t[1] - t[0], exp);
      check_eq({tag, " second interval"}, t[2] - t[1], exp);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      do_reset();
      #1;
      check_eq("R1 wave_out after reset", int'(lo_wave), 0);
      check_eq("R1 irq after reset", int'(lo_irq), 0);
      rd(1'b0, A_COUNT, d);
      check_eq("R1 count after reset", int'(d), 0);
      rd(1'b0, A_STAT, d);
      check_eq("R1 status after reset", int'(d), 0);
   endtask

   task automatic t_periodic();
      do_reset();
      wr(1'b0, A_MODE, 16'd14);      // every clock, reload on C
      wr(1'b0, A_CMPC, 16'd5);
      wr(1'b0, A_IEN, 16'd4);
      wr(1'b0, A_CTRL, 16'd5);
      measure(6, "R3 periodic C=5");
   endtask

   task automatic t_clock_select();
      do_reset();
      wr(1'b0, A_MODE, 16'd9);       // divide by 8, reload
      wr(1'b0, A_CMPC, 16'd2);
      wr(1'b0, A_IEN, 16'd4);
      wr(1'b0, A_CTRL, 16'd5);
      measure(24, "R10 div8");
      do_reset();
      wr(1'b0, A_MODE, 16'd11);      // divide by 128, reload
      wr(1'b0, A_CMPC, 16'd0);
      wr(1'b0, A_IEN, 16'd4);
      wr(1'b0, A_CTRL, 16'd5);
      measure(128, "R10 div128");
      do_reset();
      wr(1'b0, A_MODE, 16'd12);      // slow tick, reload
      wr(1'b0, A_CMPC, 16'd1);
      wr(1'b0, A_IEN, 16'd4);
      wr(1'b0, A_CTRL, 16'd5);
      measure(20, "R10 slow tick");
   endtask

   task automatic t_oneshot();
      logic [15:0] d;
      int hits = 0;
      do_reset();
      wr(1'b0, A_MODE, 16'd30);      // every clock, reload, stop on C
      wr(1'b0, A_CMPC, 16'd4);
      wr(1'b0, A_IEN, 16'd4);
      wr(1'b0, A_CTRL, 16'd5);
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (lo_irq) begin
            hits++;
            rd(1'b0, A_STAT, d);
         end
      end
      check_eq("R4 one-shot event count", hits, 1);
      rd(1'b0, A_STAT, d);
      check_eq("R4 running bit after stop", int'(d[ST_RUN]), 0);
      rd(1'b0, A_COUNT, d);
      check_eq("R4 count held after stop", int'(d), 0);
   endtask

   task automatic t_commands();
      logic [15:0] a, b, c;
      do_reset();
      wr(1'b0, A_MODE, 16'd6);       // every clock, free run
      wr(1'b0, A_CTRL, 16'd1);
      repeat (20) @(negedge clk);
      wr(1'b0, A_CTRL, 16'd2);
      rd(1'b0, A_COUNT, a);
      repeat (10) @(negedge clk);
      rd(1'b0, A_COUNT, b);
      check_eq("R6 count held while halted", int'(b), int'(a));
      wr(1'b0, A_CTRL, 16'd1);
      repeat (10) @(negedge clk);
      rd(1'b0, A_COUNT, c);
      check_eq("R6 resume from held value", int'(c > b && c < b + 16'd20), 1);
      wr(1'b0, A_CTRL, 16'd3);
      rd(1'b0, A_STAT, a);
      check_eq("R6 halt wins over enable", int'(a[ST_RUN]), 0);
      wr(1'b0, A_CTRL, 16'd4);
      rd(1'b0, A_COUNT, a);
      check_eq("R5 trigger alone zeroes count", int'(a), 0);
      wr(1'b0, A_CTRL, 16'd5);
      repeat (30) @(negedge clk);
      rd(1'b0, A_COUNT, a);
      check_eq("R5 start counts from zero", int'(a >= 16'd30 && a <= 16'd34), 1);
      wr(1'b0, A_CTRL, 16'd5);
      rd(1'b0, A_COUNT, a);
      check_eq("R5 restart zeroes running count", int'(a < 16'd4), 1);
   endtask

   task automatic t_sync();
      logic [15:0] d;
      do_reset();
      wr(1'b0, A_MODE, 16'd6);
      wr(1'b0, A_CTRL, 16'd5);
      repeat (50) @(negedge clk);
      rd(1'b0, A_COUNT, d);
      check_eq("R11 count advanced before clear", int'(d > 16'd40), 1);
      @(negedge clk);
      sync_in = 1'b1;
      @(negedge clk);
      sync_in = 1'b0;
      rd(1'b0, A_COUNT, d);
      check_eq("R11 sync clears count", int'(d < 16'd4), 1);
      repeat (10) @(negedge clk);
      rd(1'b0, A_COUNT, d);
      check_eq("R11 still running after sync", int'(d >= 16'd10), 1);
   endtask

   task automatic t_irq();
      logic [15:0] d;
      do_reset();
      wr(1'b0, A_MODE, 16'd14);
      wr(1'b0, A_CMPC, 16'd3);
      wr(1'b0, A_IEN, 16'd7);
      wr(1'b0, A_CTRL, 16'd5);
      repeat (10) @(negedge clk);
      #1 check_eq("R7 irq raised when enabled", int'(lo_irq), 1);
      wr(1'b0, A_IDIS, 16'h00FF);
      #1 check_eq("R7 irq masked by 0xFF", int'(lo_irq), 0);
      wr(1'b0, A_CTRL, 16'd2);
      rd(1'b0, A_STAT, d);
      check_eq("R8 flags kept while masked", int'(d[2:0]), 6);
      rd(1'b0, A_STAT, d);
      check_eq("R8 read cleared flags", int'(d[2:0]), 0);
      wr(1'b0, A_IEN, 16'd1);
      wr(1'b0, A_CTRL, 16'd5);
      repeat (20) @(negedge clk);
      #1 check_eq("R7 only overflow enabled keeps irq low", int'(lo_irq), 0);
   endtask

   task automatic t_pin();
      int errs = 0;
      int highs = 0;
      logic prev = 1'b0;
      int seen = 0;
      do_reset();
      wr(1'b0, A_MODE, 16'd302);     // every clock, reload, A set, C clear
      wr(1'b0, A_CMPA, 16'd2);
      wr(1'b0, A_CMPC, 16'd5);
      wr(1'b0, A_CTRL, 16'd5);
      bus_addr = A_COUNT; sel_hi = 1'b0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         #1 if (lo_wave != (lo_rdata >= 16'd3 && lo_rdata <= 16'd5)) errs++;
      end
      check_eq("R9 set on A clear on C window errors", errs, 0);
      do_reset();
      wr(1'b0, A_MODE, 16'd302);
      wr(1'b0, A_CMPA, 16'd2);
      wr(1'b0, A_CMPC, 16'd2);
      wr(1'b0, A_CTRL, 16'd5);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         #1 if (lo_wave) highs++;
      end
      check_eq("R9 C action applied after A action", highs, 0);
      do_reset();
      wr(1'b0, A_MODE, 16'd110);     // every clock, reload, A toggle
      wr(1'b0, A_CMPA, 16'd1);
      wr(1'b0, A_CMPC, 16'd3);
      wr(1'b0, A_CTRL, 16'd5);
      bus_addr = A_COUNT;
      errs = 0;
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         #1 if (lo_rdata == 16'd0) begin
            if (seen > 0 && lo_wave == prev) errs++;
            prev = lo_wave;
            seen++;
         end
      end
      check_eq("R9 toggle alternates each period", int'(errs == 0 && seen >= 4), 1);
   endtask

   task automatic t_cascade();
      logic [31:0] prev = 32'd0;
      logic [31:0] now;
      logic [15:0] d;
      int mono_err = 0;
      do_reset();
      wr(1'b1, A_MODE, 16'd5);       // upper: external edges, free run
      wr(1'b1, A_CTRL, 16'd1);
      wr(1'b0, A_MODE, 16'd294);     // lower: every clock, free run, A set, C clear
      wr(1'b0, A_CMPA, 16'h0000);
      wr(1'b0, A_CMPC, 16'h8000);
      wr(1'b0, A_IEN, 16'd1);
      @(negedge clk);
      sync_in = 1'b1;
      @(negedge clk);
      sync_in = 1'b0;
      wr(1'b0, A_CTRL, 16'd1);
      bus_addr = A_COUNT;
      for (int i = 0; i < 700; i++) begin
         repeat (100) @(negedge clk);
         #1 now = {hi_rdata, lo_rdata};
         if (lo_rdata >= 16'd8) begin
            if (now < prev) mono_err++;
            prev = now;
         end
      end
      check_eq("R12 chained count never decreases", mono_err, 0);
      check_eq("R12 upper half after two carries", int'(hi_rdata), 2);
      rd(1'b0, A_STAT, d);
      check_eq("R2 overflow flag after wrap", int'(d[SRC_OVF]), 1);
   endtask

   initial begin
      t_reset();
      t_periodic();
      t_clock_select();
      t_oneshot();
      t_commands();
      t_sync();
      t_irq();
      t_pin();
      t_cascade();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule